// File: doc/BRIEF.md
# Key-Sequence Write Gate for a Protected Control Register

This block holds one critical control register, for example the selector of a clock source, and shields it from stray software writes. It sits on a simple CPU-style register bus with an address, a write strobe, write data and a read strobe. Writes to the guarded address are normally refused. Before a write can land, software must write two key values to that same address in a fixed order. After that, the next write to the address is loaded into the register.

Each committed write locks the gate again, so every later change needs the full key sequence once more. The two keys do not have to arrive back to back. Accesses to any other address may come between them and leave the sequence untouched. The block drives read data for the guarded address, presents the register contents continuously to the logic it controls, and has a status output that is high while the gate will accept the committing write.

Top module: `keyed_reg_gate`

## Requirements
- R1: A synchronous active-low reset loads the register with the parameter RESET_VAL and leaves the gate locked (armed low).
- R2: A write of KEY_FIRST (default 0xE7) to GUARD_ADDR, and later a write of KEY_SECOND (default 0x18) to GUARD_ADDR, raises armed in the cycle after the second key write.
- R3: While armed is high, a write to GUARD_ADDR loads its data into the register, and armed is low again after that edge.
- R4: Key values in the wrong order (0x18 first, then 0xE7) do not arm the gate, and a write to GUARD_ADDR while armed is low never changes the register.
- R5: Reads of any address, and writes to addresses other than GUARD_ADDR, made between the two key writes do not disturb the sequence.
- R6: With only the first key taken, a guarded write of any value other than either key returns the gate to locked. A repeated write of KEY_FIRST in that position counts as a fresh first key.
- R7: A read of GUARD_ADDR returns the current register value on rd_data in the same cycle and leaves the unlock state unchanged. rd_data is zero when no read of GUARD_ADDR is in progress.
- R8: After a committed write, a further write to GUARD_ADDR without a new key sequence leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Register address of the current access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| rd_data | output | DATA_W | Register value during a read of GUARD_ADDR, zero otherwise |
| ctrl_value | output | DATA_W | Current contents of the protected register |
| armed | output | 1 | High while the next guarded write will be committed |

## Verification
The bench builds the gate with GUARD_ADDR set to 0x5C and RESET_VAL set to 0x3C, and keeps the default key values, so that the reset value cannot be confused with either key or with zero. With neighbouring addresses 0x5D and 0x00 used as unrelated traffic, address-decode mistakes and key interleaving faults show up. A repeated first key, a key of 0xE7 committed as data, and a reset while armed are all within reach of these values.

// File: rtl/keygate_pkg.sv
// Shared types for the key-sequence write gate.
// Assumes the unlock protocol has exactly two keys plus one committing write.
package keygate_pkg;

    // Progress of the unlock sequence.
    typedef enum logic [1:0] {
        KG_LOCKED = 2'd0,
        KG_HALF   = 2'd1,
        KG_ARMED  = 2'd2
    } kg_state_t;

endpackage

// File: rtl/keygate_decode.sv
// Address decoder: turns the bus strobes into guarded-write and guarded-read
// qualifiers. Assumes a single access per cycle and a fixed guarded address.
module keygate_decode #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] GUARD_ADDR = '0
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic              guard_wr,
    output logic              guard_rd
);

    logic addr_hit;

    // Compare the bus address with the guarded location and qualify strobes.
    always_comb begin
        addr_hit = (bus_addr == GUARD_ADDR);
        guard_wr = addr_hit && bus_wr;
        guard_rd = addr_hit && bus_rd;
    end

endmodule

// File: rtl/keygate_seq.sv
// Unlock sequencer: tracks key progress on guarded writes, flags the
// committing write and relocks after it. Assumes guard_wr is already decoded.
module keygate_seq
    import keygate_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hE7,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              guard_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              commit,
    output logic              armed
);

    kg_state_t state_q, state_d;
    logic      is_first, is_second;

    // Key recognisers on the incoming write data.
    always_comb begin
        is_first  = (wdata == KEY_FIRST);
        is_second = (wdata == KEY_SECOND);
    end

    // Next-state choice, applied only when the guarded address is written.
    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        if (guard_wr) begin
            unique case (state_q)
                KG_LOCKED: state_d = is_first ? KG_HALF : KG_LOCKED;
                KG_HALF: begin
                    if (is_second)     state_d = KG_ARMED;
                    else if (is_first) state_d = KG_HALF;
                    else               state_d = KG_LOCKED;
                end
                KG_ARMED: begin
                    commit  = 1'b1;
                    state_d = KG_LOCKED;
                end
                default: state_d = KG_LOCKED;
            endcase
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KG_LOCKED;
        else        state_q <= state_d;
    end

    // Status output: gate will accept the next guarded write.
    always_comb armed = (state_q == KG_ARMED);

endmodule

// File: rtl/keygate_store.sv
// Protected register and its read path. Loads only on commit; read data is
// driven only during a guarded read. Assumes commit is a single-cycle pulse.
module keygate_store #(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [DATA_W-1:0] wdata,
    input  logic              guard_rd,
    output logic [DATA_W-1:0] value,
    output logic [DATA_W-1:0] rd_data
);

    // Register update: reset default, else load on a committing write.
    always_ff @(posedge clk) begin
        if (!rst_n)      value <= RESET_VAL;
        else if (commit) value <= wdata;
    end

    // Read mux: present the register only while it is being read.
    always_comb rd_data = guard_rd ? value : '0;

endmodule

// File: rtl/keyed_reg_gate.sv
// Top of the key-sequence write gate. Holds one protected control register
// behind a two-key unlock on its own bus address. Assumes one bus access per
// cycle; other addresses are decoded elsewhere and are ignored here.
module keyed_reg_gate #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] GUARD_ADDR = 8'hF6,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hE7,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'h18,
    parameter logic [DATA_W-1:0] RESET_VAL  = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] ctrl_value,
    output logic              armed
);

    logic guard_wr, guard_rd, commit;

    keygate_decode #(
        .ADDR_W    (ADDR_W),
        .GUARD_ADDR(GUARD_ADDR)
    ) u_decode (
        .bus_addr(bus_addr),
        .bus_wr  (bus_wr),
        .bus_rd  (bus_rd),
        .guard_wr(guard_wr),
        .guard_rd(guard_rd)
    );

    keygate_seq #(
        .DATA_W    (DATA_W),
        .KEY_FIRST (KEY_FIRST),
        .KEY_SECOND(KEY_SECOND)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .guard_wr(guard_wr),
        .wdata   (bus_wdata),
        .commit  (commit),
        .armed   (armed)
    );

    keygate_store #(
        .DATA_W   (DATA_W),
        .RESET_VAL(RESET_VAL)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .wdata   (bus_wdata),
        .guard_rd(guard_rd),
        .value   (ctrl_value),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/keyed_reg_gate_chk.sv
// Property checker for keyed_reg_gate, attached by bind. Observes ports only.
module keyed_reg_gate_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] GUARD_ADDR = 8'hF6,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hE7,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'h18
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] ctrl_value,
    input logic              armed
);

    logic hit;
    assign hit = (bus_addr == GUARD_ADDR);

    // R2
    arm_after_second_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(bus_wr && hit && bus_wdata == KEY_SECOND));

    // R3
    commit_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && bus_wr && hit) |=> (ctrl_value == $past(bus_wdata) && !armed));

    // R4
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed && bus_wr && hit) |=> $stable(ctrl_value));

    // R5
    foreign_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && hit) |=> $stable(armed));

    // R7
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && hit) |-> (rd_data == '0));

    // R7
    guard_read_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit) |-> (rd_data == ctrl_value));

    // R6
    first_key_no_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && bus_wr && hit && bus_wdata == KEY_FIRST) |=> !armed);

endmodule

bind keyed_reg_gate keyed_reg_gate_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .GUARD_ADDR(GUARD_ADDR),
    .KEY_FIRST (KEY_FIRST),
    .KEY_SECOND(KEY_SECOND)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .rd_data   (rd_data),
    .ctrl_value(ctrl_value),
    .armed     (armed)
);

// File: tb/sim_keyed_reg_gate.sv
// Bench for keyed_reg_gate: behavioural reference model compared every clock,
// plus directed checks per requirement.
module sim_keyed_reg_gate;

    localparam logic [7:0] GA   = 8'h5C;
    localparam logic [7:0] RV   = 8'h3C;
    localparam logic [7:0] OTH1 = 8'h5D;
    localparam logic [7:0] OTH2 = 8'h00;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] rd_data, ctrl_value;
    logic       armed;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    int         m_stage = 0;
    logic [7:0] m_val = RV;

    always #10 clk = ~clk;

    keyed_reg_gate #(
        .GUARD_ADDR(GA),
        .RESET_VAL (RV)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .rd_data(rd_data),
        .ctrl_value(ctrl_value), .armed(armed)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One clock: update model at the edge, compare at the falling edge.
    task automatic cycle();
        @(posedge clk);
        cycles++;
        if (!rst_n) begin
            m_stage = 0;
            m_val = RV;
        end else if (bus_wr && bus_addr == GA) begin
            case (m_stage)
                0: m_stage = (bus_wdata == 8'hE7) ? 1 : 0;
                1: m_stage = (bus_wdata == 8'h18) ? 2 : ((bus_wdata == 8'hE7) ? 1 : 0);
                default: begin m_val = bus_wdata; m_stage = 0; end
            endcase
        end
        @(negedge clk);
        check("R3/R4 model value", ctrl_value, m_val);
        check("R2 model armed", {7'd0, armed}, {7'd0, m_stage == 2});
        check("R7 model rd_data", rd_data, (bus_rd && bus_addr == GA) ? m_val : 8'h00);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        cycle();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
        cycle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        rst_n = 1'b0;
        cycle(); cycle();
        rst_n = 1'b1;
        // R1 reset state
        check("R1 value", ctrl_value, RV);
        check("R1 armed", {7'd0, armed}, 8'd0);

        // R2 / R3 basic unlock and commit
        wr(GA, 8'hE7); wr(GA, 8'h18);
        check("R2 armed", {7'd0, armed}, 8'd1);
        wr(GA, 8'h55);
        check("R3 value", ctrl_value, 8'h55);
        check("R3 relock", {7'd0, armed}, 8'd0);

        // R8 no second write without keys
        wr(GA, 8'h99);
        check("R8 value", ctrl_value, 8'h55);

        // R4 wrong order
        wr(GA, 8'h18); wr(GA, 8'hE7);
        check("R4 armed", {7'd0, armed}, 8'd0);
        wr(GA, 8'h11);
        check("R4 value", ctrl_value, 8'h55);

        // R5 interleaved traffic
        wr(GA, 8'hE7); wr(OTH1, 8'h18); rd(OTH1); wr(OTH2, 8'hE7); rd(OTH2);
        wr(GA, 8'h18);
        check("R5 armed", {7'd0, armed}, 8'd1);
        wr(OTH1, 8'h77);
        check("R5 armed kept", {7'd0, armed}, 8'd1);
        wr(GA, 8'h66);
        check("R5 value", ctrl_value, 8'h66);

        // R6 broken sequence and repeated first key
        wr(GA, 8'hE7); wr(GA, 8'h42); wr(GA, 8'h18);
        check("R6 broken", {7'd0, armed}, 8'd0);
        wr(GA, 8'hE7); wr(GA, 8'hE7); wr(GA, 8'h18);
        check("R6 repeat first", {7'd0, armed}, 8'd1);
        wr(GA, 8'hE7);
        check("R6 key as data", ctrl_value, 8'hE7);

        // R7 reads
        rd(GA);
        check("R7 read value", rd_data, 8'hE7);
        wr(GA, 8'hE7); rd(GA); wr(GA, 8'h18);
        check("R7 read keeps progress", {7'd0, armed}, 8'd1);
        rd(GA);
        check("R7 read keeps armed", {7'd0, armed}, 8'd1);
        wr(GA, 8'h21);
        check("R7 value", ctrl_value, 8'h21);
        rd(OTH1);
        check("R7 other read zero", rd_data, 8'h00);
        bus_rd = 1'b0;

        // R1 reset while armed
        wr(GA, 8'hE7); wr(GA, 8'h18);
        rst_n = 1'b0;
        cycle();
        rst_n = 1'b1;
        check("R1 value after reset", ctrl_value, RV);
        check("R1 armed after reset", {7'd0, armed}, 8'd0);
        wr(GA, 8'h5A);
        check("R1 locked after reset", ctrl_value, RV);

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

endmodule